// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the frame-sync pulse for a PCM audio transceiver. The whole block runs in one system clock domain. Each candidate source clock is presented as a one-cycle tick that marks one source period, and a select input picks which tick stream the block counts. A half-period divider stretches every level of the bit clock over N+1 source ticks. A frame divider groups M+1 bit clocks into one frame. The frame-sync output is high for the whole first bit of each frame. For a sample rate Fs and S bit clocks per frame, software sets M = S − 1 and N = source_rate / S / Fs / 2 − 1. The default of 128 bit clocks per frame (M = 127) covers rates from 8 kHz up to 96 kHz with common source clocks.

The generator runs while the serial clock enable is set and either continuous mode is on or a transfer is active. With continuous mode off, the clock stops once the transfer ends. Stopping and reprogramming both act only at a frame boundary, so no frame is ever cut short. Besides the clock levels, the block emits one-cycle rise and fall strobes that the transceiver uses to shift data.

The controller has three states. PH_IDLE holds the clock low. PH_HIGH is the high half of a bit and PH_LOW is the low half. The transitions are:
- START: PH_IDLE to PH_HIGH, when the run condition holds. The divider values are loaded at this point.
- HALF: PH_HIGH to PH_LOW, after N+1 ticks.
- NEXT_BIT: PH_LOW to PH_HIGH, after N+1 ticks. At the last bit of a frame this also reloads the dividers.
- STOP: PH_LOW to PH_IDLE, after the last bit of a frame, when the run condition has dropped.

Top module: `pcm_clkgen`

## Requirements
- R1: After reset, and whenever the block is idle, bclk_o, fsync_o, bclk_rise_o and bclk_fall_o are all 0.
- R2: Each bit period starts with bclk_o high. The high level and the low level each last exactly N+1 ticks of the selected source, where N is the latched bit divider. With a tick on every cycle, consecutive rise strobes are therefore 2(N+1) cycles apart.
- R3: A frame holds M+1 bit periods, where M is the latched frame divider. fsync_o is high for exactly the whole first bit period of each frame, and it rises together with bclk_o.
- R4: src_sel_i = k selects src_tick_i[k]. Index 1 is the peripheral bus clock and index 0 is the audio clock. Ticks on the source that is not selected have no effect.
- R5: The run condition is sclk_en_i AND (free_run_i OR xfer_act_i). When the block is idle and the run condition holds at a clock edge, bclk_o, fsync_o and bclk_rise_o are all 1 in the cycle that follows.
- R6: When the run condition drops, the current frame completes in full. After its last low half, the block goes idle and its outputs stay 0.
- R7: New values on bit_div_i and frm_div_i are taken only at a start from idle or at the end of a frame's last bit. The frame in progress keeps its old timing.
- R8: bclk_rise_o is 1 only in the first cycle of each high level, and bclk_fall_o is 1 only in the first cycle of the low level that follows a high level. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | SRC_CNT | One tick per source clock period; [1] is the peripheral bus clock, [0] is the audio clock |
| src_sel_i | input | SEL_W | Index of the tick stream to count |
| bit_div_i | input | DIV_W | Half-period divider N |
| frm_div_i | input | DIV_W | Frame divider M (bit clocks per frame minus one) |
| sclk_en_i | input | 1 | Serial clock enable |
| free_run_i | input | 1 | Continuous mode: keep the clock running while idle |
| xfer_act_i | input | 1 | A transfer is active |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync, high during bit 0 |
| bclk_rise_o | output | 1 | First cycle of a bit clock high level |
| bclk_fall_o | output | 1 | First cycle of a bit clock low level |

## Verification
The bench goes after the frame edges. It drops the run condition in the middle of a frame and checks that the frame still finishes; a design that gates at once would emit a short final frame or a truncated bit. It changes the dividers in the middle of a frame; a design that takes them at once would produce a frame of mixed length, visible as a wrong fsync period. It also runs with N = 0 and M = 0, where fsync must stay high across frames and the strobes alternate every cycle, and with an irregular audio tick and a switch to the slower bus tick, where an off-by-one in the half counter shows up as a wrong rise-to-rise gap.

// File: rtl/pcmclk_pkg.sv
package pcmclk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/pcmclk_src_mux.sv
module pcmclk_src_mux #(
    parameter int SRC_CNT = 2,
    parameter int SEL_W   = $clog2(SRC_CNT)
) (
    input  logic [SRC_CNT-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);

    logic [SRC_CNT-1:0] hit;

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
        assign hit[i] = tick_i[i] && (sel_i == SEL_W'(i));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/pcmclk_half_div.sv
module pcmclk_half_div #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             half_end_o
);

    logic [DIV_W-1:0] cnt;
    logic             at_lim;

    assign at_lim     = (cnt == lim_i);
    assign half_end_o = run_i && tick_i && at_lim;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= at_lim ? '0 : cnt + 1'b1;
        end
    end

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt <= lim_i)); // R2

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt)); // R2

endmodule

// File: rtl/pcmclk_frame_seq.sv
module pcmclk_frame_seq #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             bit_end_i,
    input  logic [DIV_W-1:0] bit_div_i,
    input  logic [DIV_W-1:0] frm_div_i,
    output logic [DIV_W-1:0] act_bit_div_o,
    output logic             first_bit_o,
    output logic             last_bit_o
);

    logic [DIV_W-1:0] bcnt;
    logic [DIV_W-1:0] act_frm;

    assign first_bit_o = (bcnt == '0);
    assign last_bit_o  = (bcnt == act_frm);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt          <= '0;
            act_frm       <= '0;
            act_bit_div_o <= '0;
        end else if (load_i) begin
            bcnt          <= '0;
            act_frm       <= frm_div_i;
            act_bit_div_o <= bit_div_i;
        end else if (bit_end_i) begin
            if (last_bit_o) begin
                bcnt          <= '0;
                act_frm       <= frm_div_i;
                act_bit_div_o <= bit_div_i;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(bit_end_i && last_bit_o)) |=>
            ($stable(act_frm) && $stable(act_bit_div_o))); // R7

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= act_frm); // R3

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
    import pcmclk_pkg::*;
#(
    parameter int SRC_CNT = 2,
    parameter int DIV_W   = 9,
    parameter int SEL_W   = $clog2(SRC_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_CNT-1:0] src_tick_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    input  logic [DIV_W-1:0]   bit_div_i,
    input  logic [DIV_W-1:0]   frm_div_i,
    input  logic               sclk_en_i,
    input  logic               free_run_i,
    input  logic               xfer_act_i,
    output logic               bclk_o,
    output logic               fsync_o,
    output logic               bclk_rise_o,
    output logic               bclk_fall_o
);

    phase_e           phase, phase_nxt;
    logic             prev_high;
    logic             want_run;
    logic             tick;
    logic             half_run;
    logic             half_end;
    logic             bit_end;
    logic             load;
    logic             first_bit;
    logic             last_bit;
    logic [DIV_W-1:0] act_bit_div;

    assign want_run = sclk_en_i && (free_run_i || xfer_act_i);
    assign half_run = (phase != PH_IDLE);
    assign bit_end  = half_end && (phase == PH_LOW);
    assign load     = (phase == PH_IDLE) && want_run;

    pcmclk_src_mux #(
        .SRC_CNT (SRC_CNT),
        .SEL_W   (SEL_W)
    ) u_mux (
        .tick_i (src_tick_i),
        .sel_i  (src_sel_i),
        .tick_o (tick)
    );

    pcmclk_half_div #(
        .DIV_W (DIV_W)
    ) u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (half_run),
        .tick_i     (tick),
        .lim_i      (act_bit_div),
        .half_end_o (half_end)
    );

    pcmclk_frame_seq #(
        .DIV_W (DIV_W)
    ) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .bit_end_i     (bit_end),
        .bit_div_i     (bit_div_i),
        .frm_div_i     (frm_div_i),
        .act_bit_div_o (act_bit_div),
        .first_bit_o   (first_bit),
        .last_bit_o    (last_bit)
    );

    // next-state decode
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (want_run) phase_nxt = PH_HIGH;             // START
            PH_HIGH: if (half_end) phase_nxt = PH_LOW;              // HALF
            PH_LOW: begin
                if (half_end) begin
                    if (last_bit && !want_run) phase_nxt = PH_IDLE; // STOP
                    else                       phase_nxt = PH_HIGH; // NEXT_BIT
                end
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            prev_high <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            prev_high <= (phase == PH_HIGH);
        end
    end

    // outputs
    always_comb begin
        bclk_o      = (phase == PH_HIGH);
        fsync_o     = (phase != PH_IDLE) && first_bit;
        bclk_rise_o = (phase == PH_HIGH) && !prev_high;
        bclk_fall_o = (phase == PH_LOW) && prev_high;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise_o && bclk_fall_o)); // R8

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW && !last_bit) |=> (phase != PH_IDLE)); // R6

    AST_FSYNC_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> bclk_rise_o); // R3

    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && want_run) |=> (bclk_rise_o && fsync_o)); // R5

endmodule

// File: tb/sim_pcm_clkgen.sv
module sim_pcm_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_tick;
    logic       src_sel = 1'b0;
    logic [8:0] bit_div = 9'd2;
    logic [8:0] frm_div = 9'd3;
    logic       sclk_en = 1'b0;
    logic       free_run = 1'b0;
    logic       xfer_act = 1'b0;
    logic       bclk, fsync, rise, fall;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    string phase_req = "R1";

    // tick stimulus: [1] bus every 3rd cycle, [0] audio per mode
    int aud_mode = 0;
    int bus_cnt = 0;
    int lfsr = 32'h1ace;

    always #10 clk = ~clk;

    pcm_clkgen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick_i  (src_tick),
        .src_sel_i   (src_sel),
        .bit_div_i   (bit_div),
        .frm_div_i   (frm_div),
        .sclk_en_i   (sclk_en),
        .free_run_i  (free_run),
        .xfer_act_i  (xfer_act),
        .bclk_o      (bclk),
        .fsync_o     (fsync),
        .bclk_rise_o (rise),
        .bclk_fall_o (fall)
    );

    initial src_tick = 2'b00;
    always @(negedge clk) begin
        bus_cnt = (bus_cnt == 2) ? 0 : bus_cnt + 1;
        lfsr = (lfsr << 1) ^ (((lfsr >> 31) & 1) != 0 ? 32'h04c11db7 : 0);
        src_tick[1] <= (bus_cnt == 0);
        src_tick[0] <= (aud_mode == 0) ? 1'b1 : lfsr[3];
    end

    // behavioural reference: 0 idle, 1 high half, 2 low half
    int m_st = 0, m_hc = 0, m_bc = 0, m_n = 0, m_m = 0;
    bit m_prev = 0;
    always @(posedge clk) begin
        bit run, tk;
        run = sclk_en && (free_run || xfer_act);
        tk = src_tick[src_sel];
        m_prev = (m_st == 1);
        if (!rst_n) begin
            m_st = 0; m_hc = 0; m_bc = 0; m_n = 0; m_m = 0; m_prev = 0;
        end else if (m_st == 0) begin
            if (run) begin
                m_st = 1; m_hc = 0; m_bc = 0; m_n = bit_div; m_m = frm_div;
            end
        end else if (tk) begin
            if (m_hc < m_n) m_hc++;
            else begin
                m_hc = 0;
                if (m_st == 1) m_st = 2;
                else if (m_bc == m_m) begin
                    m_bc = 0; m_n = bit_div; m_m = frm_div;
                    m_st = run ? 1 : 0;
                end else begin
                    m_bc++; m_st = 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit e_b, e_f, e_r, e_l;
            e_b = (m_st == 1);
            e_f = (m_st != 0) && (m_bc == 0);
            e_r = (m_st == 1) && !m_prev;
            e_l = (m_st == 2) && m_prev;
            check(bclk == e_b, "R2", {"bclk in ", phase_req}, bclk, e_b);
            check(fsync == e_f, "R3", {"fsync in ", phase_req}, fsync, e_f);
            check(rise == e_r, "R8", {"rise in ", phase_req}, rise, e_r);
            check(fall == e_l, "R8", {"fall in ", phase_req}, fall, e_l);
        end
    end

    task automatic rise_gap(output int gap);
        while (!rise) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!rise);
    endtask

    task automatic fsync_span(output int hi, output int per);
        while (!(fsync && rise)) @(negedge clk);
        hi = 0; per = 0;
        while (fsync) begin @(negedge clk); hi++; per++; end
        while (!fsync) begin @(negedge clk); per++; end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #1;
        while (cyc < 100000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int g, hi, per;
        repeat (3) @(negedge clk);
        check(!bclk && !fsync && !rise && !fall, "R1", "outputs in reset",
              {bclk, fsync, rise, fall}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({bclk, fsync, rise, fall} == 4'b0, "R1", "idle after reset",
              {bclk, fsync, rise, fall}, 0);

        // R5: start from idle
        phase_req = "R5";
        sclk_en = 1'b1; free_run = 1'b1;
        @(negedge clk);
        check(bclk && fsync && rise, "R5", "wake cycle", {bclk, fsync, rise}, 7);

        // R2 / R3 with a tick on every cycle, N=2, M=3
        phase_req = "R2";
        rise_gap(g);
        check(g == 6, "R2", "rise gap N=2", g, 6);
        phase_req = "R3";
        fsync_span(hi, per);
        check(hi == 6, "R3", "fsync width", hi, 6);
        check(per == 24, "R3", "frame period", per, 24);

        // R4: bus source, ticks every third cycle
        phase_req = "R4";
        src_sel = 1'b1;
        repeat (60) @(negedge clk);
        rise_gap(g);
        check(g == 18, "R4", "rise gap on bus tick", g, 18);

        // R7: change dividers mid-frame
        phase_req = "R7";
        src_sel = 1'b0;
        repeat (30) @(negedge clk);
        while (!(fsync && fall)) @(negedge clk);
        bit_div = 9'd1; frm_div = 9'd5;
        rise_gap(g);
        check(g == 6, "R7", "old timing kept in frame", g, 6);
        fsync_span(hi, per);
        check(per == 24, "R7", "new frame length", per, 24);
        check(hi == 4, "R7", "new fsync width", hi, 4);

        // R6: gated mode, transfer ends mid-frame
        phase_req = "R6";
        free_run = 1'b0; xfer_act = 1'b1;
        repeat (40) @(negedge clk);
        while (!(fsync && fall)) @(negedge clk);
        xfer_act = 1'b0;
        g = 0;
        while (bclk || fall || m_st != 0) begin @(negedge clk); g++; end
        check(g >= 20, "R6", "frame completed before stop", g, 20);
        repeat (50) @(negedge clk);
        check({bclk, fsync, rise, fall} == 4'b0, "R6", "quiet when stopped",
              {bclk, fsync, rise, fall}, 0);

        // R5: clock enable low in continuous mode
        phase_req = "R5";
        free_run = 1'b1;
        repeat (100) @(negedge clk);
        sclk_en = 1'b0;
        repeat (150) @(negedge clk);
        check(!bclk && !fsync, "R5", "enable low stops", {bclk, fsync}, 0);

        // R2 / R3 corner: N=0, M=0, irregular audio ticks
        phase_req = "R2";
        bit_div = 9'd0; frm_div = 9'd0; aud_mode = 0;
        sclk_en = 1'b1;
        repeat (3) @(negedge clk);
        rise_gap(g);
        check(g == 2, "R2", "rise gap N=0", g, 2);
        check(fsync == 1'b1, "R3", "fsync held for M=0", fsync, 1);
        aud_mode = 1;
        bit_div = 9'd3; frm_div = 9'd7;
        repeat (600) @(negedge clk);
        finish_run();
    end

endmodule